// File: doc/BRIEF.md
# Wake-up Controller State Machine

This block is a small three-state controller that models a sleeper reacting to an alarm. Each clock it samples two single-bit inputs: `alarm_on`, which is high while the alarm sounds, and `weekday`, which is high on a working day. It produces one output, `silence_req`, which asks for the alarm to be switched off. The present state code is brought out on `state_code` so that it can be observed.

The states are named and coded as follows: sleeping (`ST_ASLEEP`, 2'b00), lying awake (`ST_IN_BED`, 2'b01) and risen (`ST_UP`, 2'b10). The transitions are:

- **ring**: sleeping to lying awake while the alarm is on.
- **doze**: sleeping stays sleeping while the alarm is off.
- **snooze-hold**: lying awake stays lying awake while the alarm is on.
- **rise**: lying awake goes to risen when the alarm is off on a weekday.
- **fall-back**: lying awake returns to sleeping when the alarm is off on a non-working day.
- **stay-up**: risen stays risen whatever the inputs.

The conditions on the arcs leaving any one state exclude each other. The unused code 2'b11 leads back to sleeping on the next clock.

The parameter `MEALY_OUT` selects how the output is formed. With 0 (Moore), `silence_req` is decoded from the registered state alone. With 1 (Mealy), it is formed combinationally from the present state and `alarm_on`, so that it marks the ring and snooze-hold transitions in the same cycle as the input.

Top module: `wake_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_code` is 2'b00 (sleeping) after that edge. While `rst` is high, the Mealy output is low.
- R2: In sleeping (2'b00) with `alarm_on` low, the next state is sleeping (2'b00). `weekday` has no effect here.
- R3: In sleeping (2'b00) with `alarm_on` high, the next state is lying awake (2'b01).
- R4: In lying awake (2'b01) with `alarm_on` high, the next state is lying awake (2'b01). `weekday` has no effect here.
- R5: In lying awake (2'b01) with `alarm_on` low and `weekday` high, the next state is risen (2'b10).
- R6: In lying awake (2'b01) with `alarm_on` low and `weekday` low, the next state is sleeping (2'b00).
- R7: Risen (2'b10) is absorbing. The next state is 2'b10 for every input value until `rst` is applied.
- R8: With `MEALY_OUT`=0, `silence_req` is high exactly while `state_code` is 2'b01.
- R9: With `MEALY_OUT`=1 and `rst` low, `silence_req` is high in the same cycle exactly when `alarm_on` is high and `state_code` is 2'b00 or 2'b01. It is low in 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alarm_on | input | 1 | Alarm is sounding |
| weekday | input | 1 | Today is a working day |
| silence_req | output | 1 | Request to switch the alarm off |
| state_code | output | 2 | Present state code (00 sleeping, 01 lying awake, 10 risen) |

## Verification
The hardest situation to reach is one in which the machine leaves the risen state and explores the other arcs again. Risen absorbs every input, so a long run of stimulus without reset stays there and teaches nothing. The bench therefore starts with a directed sequence that takes every arc in turn and uses resets to escape risen, including weekday toggles in sleeping, lying awake and risen. It follows this with a long pseudo-random run in which reset is asserted now and then, so the machine keeps re-entering sleeping and lying awake. A Moore instance and a Mealy instance run side by side against one behavioural model, compared every cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ASLEEP = 2'b00,
        ST_IN_BED = 2'b01,
        ST_UP     = 2'b10
    } wake_state_e;

endpackage

// File: rtl/wake_next.sv
module wake_next
    import wake_pkg::*;
(
    input  wake_state_e cur_state,
    input  logic        alarm_on,
    input  logic        weekday,
    output wake_state_e nxt_state
);

    always_comb begin
        unique case (cur_state)
            ST_ASLEEP: begin
                if (alarm_on) nxt_state = ST_IN_BED;   // ring
                else          nxt_state = ST_ASLEEP;   // doze
            end
            ST_IN_BED: begin
                if (alarm_on)     nxt_state = ST_IN_BED; // snooze-hold
                else if (weekday) nxt_state = ST_UP;     // rise
                else              nxt_state = ST_ASLEEP; // fall-back
            end
            ST_UP: begin
                nxt_state = ST_UP;                       // stay-up
            end
            default: begin
                nxt_state = ST_ASLEEP;                   // unused code recovers
            end
        endcase
    end

endmodule

// File: rtl/wake_state_reg.sv
module wake_state_reg
    import wake_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  wake_state_e nxt_state,
    output wake_state_e cur_state
);

    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_ASLEEP;
        else     cur_state <= nxt_state;
    end

    AST_RESET_TO_ASLEEP: assert property (@(posedge clk)
        rst |=> (cur_state == ST_ASLEEP)); // R1

endmodule

// File: rtl/wake_out.sv
module wake_out
    import wake_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0
)(
    input  logic        clk,
    input  logic        rst,
    input  wake_state_e cur_state,
    input  logic        alarm_on,
    output logic        silence_req
);

    generate
        if (MEALY_OUT) begin : g_mealy
            always_comb begin
                unique case (cur_state)
                    ST_ASLEEP: silence_req = !rst && alarm_on; // ring
                    ST_IN_BED: silence_req = !rst && alarm_on; // snooze-hold
                    default:   silence_req = 1'b0;
                endcase
            end

            AST_MEALY_NEEDS_ALARM: assert property (@(posedge clk) disable iff (rst)
                silence_req |-> alarm_on); // R9
        end else begin : g_moore
            always_comb begin
                unique case (cur_state)
                    ST_IN_BED: silence_req = 1'b1;
                    default:   silence_req = 1'b0;
                endcase
            end

            AST_MOORE_FOLLOWS_STATE: assert property (@(posedge clk) disable iff (rst)
                !$stable(silence_req) |-> !$stable(cur_state)); // R8
        end
    endgenerate

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import wake_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               alarm_on,
    input  logic               weekday,
    output logic               silence_req,
    output logic [STATE_W-1:0] state_code
);

    wake_state_e cur_state;
    wake_state_e nxt_state;

    wake_next u_next (
        .cur_state (cur_state),
        .alarm_on  (alarm_on),
        .weekday   (weekday),
        .nxt_state (nxt_state)
    );

    wake_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    wake_out #(.MEALY_OUT(MEALY_OUT)) u_out (
        .clk         (clk),
        .rst         (rst),
        .cur_state   (cur_state),
        .alarm_on    (alarm_on),
        .silence_req (silence_req)
    );

    assign state_code = cur_state;

    AST_DOZE: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_ASLEEP && !alarm_on) |=> (cur_state == ST_ASLEEP)); // R2
    AST_RING: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_ASLEEP && alarm_on) |=> (cur_state == ST_IN_BED)); // R3
    AST_SNOOZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_IN_BED && alarm_on) |=> (cur_state == ST_IN_BED)); // R4
    AST_RISE: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_IN_BED && !alarm_on && weekday) |=> (cur_state == ST_UP)); // R5
    AST_FALL_BACK: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_IN_BED && !alarm_on && !weekday) |=> (cur_state == ST_ASLEEP)); // R6
    AST_STAY_UP: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_UP) |=> (cur_state == ST_UP)); // R7

endmodule

// File: tb/wake_ctrl_tb.sv
module wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alarm_on = 1'b0;
    logic       weekday = 1'b0;
    logic       req_moore;
    logic       req_mealy;
    logic [1:0] code_moore;
    logic [1:0] code_mealy;

    int checks = 0;
    int failures = 0;
    int ms = -1;              // model state: 0 sleeping, 1 lying awake, 2 risen, -1 unknown
    string last_tag = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;     // 125 MHz

    wake_ctrl #(.MEALY_OUT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .alarm_on(alarm_on), .weekday(weekday),
        .silence_req(req_moore), .state_code(code_moore)
    );

    wake_ctrl #(.MEALY_OUT(1'b1)) u_dut_mealy (
        .clk(clk), .rst(rst), .alarm_on(alarm_on), .weekday(weekday),
        .silence_req(req_mealy), .state_code(code_mealy)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic a, input logic w, input logic r);
        int exp_mealy;
        @(negedge clk);
        alarm_on = a;
        weekday  = w;
        rst      = r;
        #1;
        if (ms >= 0) begin
            check(int'(code_moore), ms, last_tag, "moore state_code");
            check(int'(code_mealy), ms, last_tag, "mealy state_code");
            check(int'(req_moore), (ms == 1) ? 1 : 0, "R8", "moore silence_req");
            exp_mealy = (!r && a && ms != 2) ? 1 : 0;
            check(int'(req_mealy), exp_mealy, r ? "R1" : "R9", "mealy silence_req");
        end else if (r) begin
            check(int'(req_mealy), 0, "R1", "mealy silence_req in reset");
        end
        @(posedge clk);
        if (r) begin
            ms = 0; last_tag = "R1";
        end else if (ms == 0) begin
            if (a) begin ms = 1; last_tag = "R3"; end
            else   begin ms = 0; last_tag = "R2"; end
        end else if (ms == 1) begin
            if (a)      begin ms = 1; last_tag = "R4"; end
            else if (w) begin ms = 2; last_tag = "R5"; end
            else        begin ms = 0; last_tag = "R6"; end
        end else if (ms == 2) begin
            ms = 2; last_tag = "R7";
        end
    endtask

    initial begin
        step(0, 0, 1);
        step(0, 0, 1);               // R1 reset state
        step(0, 1, 0);               // R2 doze, weekday ignored
        step(0, 0, 0);
        step(1, 1, 0);               // R3 ring
        step(1, 0, 0);               // R4 snooze-hold
        step(1, 1, 0);               // R4 weekday ignored
        step(0, 0, 0);               // R6 fall-back
        step(1, 0, 0);               // R3
        step(0, 1, 0);               // R5 rise
        step(1, 1, 0);               // R7 stay-up
        step(0, 0, 0);
        step(1, 0, 0);
        step(0, 1, 0);
        step(1, 1, 1);               // R1 reset out of risen, mealy low
        step(1, 0, 0);               // R3 then R9 in-bed
        step(1, 0, 1);               // R1 reset from lying awake
        step(0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] rnd = $urandom;
            step(rnd[0], rnd[1], rnd[7:4] == 4'd0);
        end
        step(0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule